// File: doc/BRIEF.md
# Mailbox Virtual Register Bridge

This block sits on the embedded-controller side of a ten-byte host I/O window. The host cannot reach the controller's 16-bit virtual register space directly. It builds a small request packet in an internal mailbox instead. It moves a 16-bit mailbox pointer through two window bytes and reaches four consecutive mailbox bytes at that pointer through four more window bytes. It then writes a doorbell byte to start the command.

When the doorbell rings, the block waits a configurable number of cycles and then decodes the packet. A valid packet is passed to a small virtual register store over a valid/ready request channel. A read result goes back into the packet's value byte. The block then raises a completion bit in a write-1-to-clear interrupt source byte and places a result code in a status byte. The store models two coupled-register cases:
- reading the low byte of a 16-bit pair freezes the high byte;
- reading the high byte of a 12-bit pair freezes the companion nibble byte.

On the internal request channel, a request stays valid with a constant payload until the store asserts ready. The store asserts ready only when it has no response pending. Each response is valid for exactly one cycle after acceptance and is never back-pressured.

Top module: `mbx_vreg_bridge`

## Requirements
- R1: After reset, every window offset (0, 1, 2, 3, 8, 9) reads 0x00 and `host_irq` is low.
- R2: A write to offset 2 sets the low byte of the mailbox pointer and a write to offset 3 sets the high byte. Both bytes read back unchanged.
- R3: Offsets 4 to 7 read and write mailbox byte (pointer + k) modulo MBOX_DEPTH, where k is the offset minus 4, but only when the pointer lies in region 1 (base 0x8000). With any other pointer these offsets read 0x00 and ignore writes.
- R4: Writing 0x01 to offset 0 while idle starts a command, and offset 0 then reads 0x01 until the command completes. Any other doorbell value is ignored.
- R5: Completion sets bit 0 of offset 8 and drives `host_irq` high. After the doorbell write edge this happens exactly EXEC_CYCLES+2 cycles later for an executed access and exactly EXEC_CYCLES cycles later for a rejected packet.
- R6: Packet byte 0 is the access type (0x02 read, 0x03 write) and byte 1 is the entry count. Byte 4 holds the write value or receives the read value. Bytes 6 and 7 hold the virtual address, low byte first. A successful command leaves 0x01 at offset 1.
- R7: Packet checks run in this order. An access type other than 0x02/0x03 gives status 0x10. Otherwise, an entry count other than 1 gives 0x11. Otherwise, an address at or above NREGS gives 0x12. A rejected packet still sets the completion bit and leaves the store unchanged.
- R8: Offset 1 is cleared to 0x00 only by writing back exactly its current value. Any other value leaves it unchanged.
- R9: Writing a 1 to bit 0 of offset 8 clears the completion bit and `host_irq`. Writing 0 to bit 0 has no effect.
- R10: Reading virtual address PAIR_LO returns its own byte and freezes the byte at PAIR_LO+1. A read of PAIR_LO+1 returns that frozen copy until PAIR_LO is read again.
- R11: Reading virtual address NIB_HI freezes the byte at NIB_LO. A read of NIB_LO returns that frozen copy until NIB_HI is read again.
- R12: While a command runs, host writes to offsets 0 and 2 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 4 | Window offset (0 to 9 used) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at `host_addr`, combinational |
| host_irq | output | 1 | Mirrors the completion bit |

## Verification
The bench sweeps every pointer position against every window lane, so that wrap-around at the end of the mailbox is covered. A design that wrapped incorrectly would return the wrong byte near the last locations. It writes and reads back every virtual address, and it measures completion latency to the exact cycle for both executed and rejected packets, which catches an off-by-one in the wait counter.

The coupled registers are checked by changing the companion byte between the two reads. A design without the freeze would return the new value instead of the captured one.

Error precedence is checked with packets that carry both a bad type and a bad count. An out-of-range address equal to NREGS is used to catch a store that silently writes to address 0 by wrap-around. Writes made during a running command are checked afterwards through the pointer and value bytes, which would show any corruption of the packet.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [3:0] OFS_BELL   = 4'd0;
  localparam logic [3:0] OFS_STAT   = 4'd1;
  localparam logic [3:0] OFS_PLO    = 4'd2;
  localparam logic [3:0] OFS_PHI    = 4'd3;
  localparam logic [3:0] OFS_IRQSRC = 4'd8;
  localparam logic [3:0] OFS_IRQSR2 = 4'd9;

  localparam logic [7:0] ACC_READ  = 8'h02;
  localparam logic [7:0] ACC_WRITE = 8'h03;
  localparam logic [7:0] BELL_GO   = 8'h01;

  localparam logic [7:0] RC_NONE     = 8'h00;
  localparam logic [7:0] RC_OK       = 8'h01;
  localparam logic [7:0] RC_BAD_TYPE = 8'h10;
  localparam logic [7:0] RC_BAD_CNT  = 8'h11;
  localparam logic [7:0] RC_BAD_ADDR = 8'h12;

  localparam int PK_TYPE  = 0;
  localparam int PK_CNT   = 1;
  localparam int PK_VAL   = 4;
  localparam int PK_ADDRL = 6;
  localparam int PK_ADDRH = 7;

  typedef enum logic [1:0] {ENG_IDLE, ENG_WAIT, ENG_REQ, ENG_RSP} eng_state_e;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } vreq_t;
endpackage

// File: rtl/mbx_mailbox.sv
module mbx_mailbox #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [3:0]       host_addr,
  input  logic [7:0]       host_wdata,
  input  logic             lock,
  input  logic             eng_we,
  input  logic [7:0]       eng_wdata,
  output logic [15:0]      ptr,
  output logic [3:0][7:0]  win_rdata,
  output logic [7:0]       pkt_type,
  output logic [7:0]       pkt_cnt,
  output logic [7:0]       pkt_val,
  output logic [15:0]      pkt_vaddr
);
  import mbx_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam logic [15-AW:0] REGION1 = {1'b1, {(15-AW){1'b0}}};

  logic [7:0]    mem [DEPTH];
  logic [15:0]   ptr_q;
  logic          in_region;
  logic [AW-1:0] lane_idx [4];

  assign ptr       = ptr_q;
  assign in_region = (ptr_q[15:AW] == REGION1);

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_idx[k]  = ptr_q[AW-1:0] + AW'(k);
    assign win_rdata[k] = in_region ? mem[lane_idx[k]] : 8'h00;
  end

  assign pkt_type  = mem[AW'(PK_TYPE)];
  assign pkt_cnt   = mem[AW'(PK_CNT)];
  assign pkt_val   = mem[AW'(PK_VAL)];
  assign pkt_vaddr = {mem[AW'(PK_ADDRH)], mem[AW'(PK_ADDRL)]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (eng_we) begin
      mem[AW'(PK_VAL)] <= eng_wdata;
    end else if (host_we && !lock) begin
      if (host_addr == OFS_PLO)      ptr_q[7:0]  <= host_wdata;
      else if (host_addr == OFS_PHI) ptr_q[15:8] <= host_wdata;
      else if (host_addr[3:2] == 2'b01 && in_region)
        mem[lane_idx[host_addr[1:0]]] <= host_wdata;
    end
  end
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine #(
  parameter int EXEC_CYCLES = 8,
  parameter int NREGS       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [3:0]         host_addr,
  input  logic [7:0]         host_wdata,
  input  logic [7:0]         pkt_type,
  input  logic [7:0]         pkt_cnt,
  input  logic [7:0]         pkt_val,
  input  logic [15:0]        pkt_vaddr,
  output logic               busy,
  output logic               done,
  output logic [7:0]         status,
  output logic               isr_bit,
  output logic               req_valid,
  output mbx_pkg::vreq_t     req,
  input  logic               req_ready,
  input  logic               rsp_valid,
  input  logic [7:0]         rsp_rdata,
  output logic               mbx_we,
  output logic [7:0]         mbx_wdata
);
  import mbx_pkg::*;

  localparam int CW = $clog2(EXEC_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(EXEC_CYCLES - 1);

  eng_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic [7:0]    status_q, chk_code, fin_code;
  logic          isr_q;
  vreq_t         req_q;
  logic          start, wait_end;

  assign start    = host_we && host_addr == OFS_BELL && host_wdata == BELL_GO && st_q == ENG_IDLE;
  assign wait_end = st_q == ENG_WAIT && cnt_q == '0;

  always_comb begin
    if (pkt_type != ACC_READ && pkt_type != ACC_WRITE) chk_code = RC_BAD_TYPE;
    else if (pkt_cnt != 8'd1)                          chk_code = RC_BAD_CNT;
    else if (pkt_vaddr >= 16'(NREGS))                  chk_code = RC_BAD_ADDR;
    else                                               chk_code = RC_OK;
  end

  always_comb begin
    st_d     = st_q;
    done     = 1'b0;
    fin_code = RC_OK;
    mbx_we   = 1'b0;
    unique case (st_q)
      ENG_IDLE: if (start) st_d = ENG_WAIT;
      ENG_WAIT: if (wait_end) begin
        if (chk_code != RC_OK) begin
          done     = 1'b1;
          fin_code = chk_code;
          st_d     = ENG_IDLE;
        end else begin
          st_d = ENG_REQ;
        end
      end
      ENG_REQ: if (req_ready) st_d = ENG_RSP;
      ENG_RSP: if (rsp_valid) begin
        done   = 1'b1;
        mbx_we = !req_q.we;
        st_d   = ENG_IDLE;
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ENG_IDLE;
      cnt_q    <= '0;
      status_q <= RC_NONE;
      isr_q    <= 1'b0;
      req_q    <= '0;
    end else begin
      st_q <= st_d;
      if (start) cnt_q <= CNT_LOAD;
      else if (st_q == ENG_WAIT && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (wait_end) req_q <= '{we: (pkt_type == ACC_WRITE), addr: pkt_vaddr, wdata: pkt_val};
      if (done) status_q <= fin_code;
      else if (host_we && host_addr == OFS_STAT && host_wdata == status_q) status_q <= RC_NONE;
      if (done) isr_q <= 1'b1;
      else if (host_we && host_addr == OFS_IRQSRC && host_wdata[0]) isr_q <= 1'b0;
    end
  end

  assign busy      = st_q != ENG_IDLE;
  assign status    = status_q;
  assign isr_bit   = isr_q;
  assign req_valid = st_q == ENG_REQ;
  assign req       = req_q;
  assign mbx_wdata = rsp_rdata;
endmodule

// File: rtl/mbx_vreg_store.sv
module mbx_vreg_store #(
  parameter int NREGS   = 16,
  parameter int PAIR_LO = 4,
  parameter int NIB_HI  = 8,
  parameter int NIB_LO  = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  mbx_pkg::vreq_t req,
  output logic           req_ready,
  output logic           rsp_valid,
  output logic [7:0]     rsp_rdata
);
  localparam int AW = $clog2(NREGS);
  localparam logic [AW-1:0] I_PLO = AW'(PAIR_LO);
  localparam logic [AW-1:0] I_PHI = AW'(PAIR_LO + 1);
  localparam logic [AW-1:0] I_NHI = AW'(NIB_HI);
  localparam logic [AW-1:0] I_NLO = AW'(NIB_LO);

  logic [7:0]    regs [NREGS];
  logic [7:0]    hi_frozen, nib_frozen, rd_byte;
  logic          rsp_q;
  logic [7:0]    rdata_q;
  logic [AW-1:0] idx;

  assign idx       = req.addr[AW-1:0];
  assign req_ready = !rsp_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  always_comb begin
    if (idx == I_PHI)      rd_byte = hi_frozen;
    else if (idx == I_NLO) rd_byte = nib_frozen;
    else                   rd_byte = regs[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      hi_frozen  <= '0;
      nib_frozen <= '0;
      rsp_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      rsp_q <= req_valid && req_ready;
      if (req_valid && req_ready) begin
        if (req.we) begin
          regs[idx] <= req.wdata;
          rdata_q   <= '0;
        end else begin
          rdata_q <= rd_byte;
          if (idx == I_PLO) hi_frozen  <= regs[I_PHI];
          if (idx == I_NHI) nib_frozen <= regs[I_NLO];
        end
      end
    end
  end
endmodule

// File: rtl/mbx_vreg_bridge.sv
module mbx_vreg_bridge #(
  parameter int MBOX_DEPTH  = 16,
  parameter int EXEC_CYCLES = 8,
  parameter int NREGS       = 16,
  parameter int PAIR_LO     = 4,
  parameter int NIB_HI      = 8,
  parameter int NIB_LO      = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_irq
);
  import mbx_pkg::*;

  logic           busy, eng_done, isr_bit, mbx_we;
  logic [7:0]     status_q, mbx_wdata, pkt_type, pkt_cnt, pkt_val, rsp_rdata;
  logic [15:0]    ptr, pkt_vaddr;
  logic [3:0][7:0] win_rdata;
  logic           req_valid, req_ready, rsp_valid;
  vreq_t          req;

  mbx_mailbox #(.DEPTH(MBOX_DEPTH)) u_mbox (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .lock(busy), .eng_we(mbx_we), .eng_wdata(mbx_wdata),
    .ptr(ptr), .win_rdata(win_rdata), .pkt_type(pkt_type), .pkt_cnt(pkt_cnt),
    .pkt_val(pkt_val), .pkt_vaddr(pkt_vaddr)
  );

  mbx_engine #(.EXEC_CYCLES(EXEC_CYCLES), .NREGS(NREGS)) u_eng (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .pkt_type(pkt_type), .pkt_cnt(pkt_cnt),
    .pkt_val(pkt_val), .pkt_vaddr(pkt_vaddr), .busy(busy), .done(eng_done),
    .status(status_q), .isr_bit(isr_bit), .req_valid(req_valid), .req(req),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mbx_we(mbx_we), .mbx_wdata(mbx_wdata)
  );

  mbx_vreg_store #(.NREGS(NREGS), .PAIR_LO(PAIR_LO), .NIB_HI(NIB_HI), .NIB_LO(NIB_LO)) u_store (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req(req),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always_comb begin
    host_rdata = 8'h00;
    case (host_addr)
      OFS_BELL:   host_rdata = {7'd0, busy};
      OFS_STAT:   host_rdata = status_q;
      OFS_PLO:    host_rdata = ptr[7:0];
      OFS_PHI:    host_rdata = ptr[15:8];
      4'd4, 4'd5, 4'd6, 4'd7: host_rdata = win_rdata[host_addr[1:0]];
      OFS_IRQSRC: host_rdata = {7'd0, isr_bit};
      OFS_IRQSR2: host_rdata = 8'h00;
      default:    host_rdata = 8'h00;
    endcase
  end

  assign host_irq = isr_bit;
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int EXEC_CYCLES = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           isr_bit,
  input logic [7:0]     status,
  input logic [15:0]    ptr,
  input logic           host_we,
  input logic [3:0]     host_addr,
  input logic [7:0]     host_wdata,
  input logic           req_valid,
  input logic           req_ready,
  input mbx_pkg::vreq_t req
);
  logic [15:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) wait_cnt <= '0;
    else if (wait_cnt != 16'hFFFF) wait_cnt <= wait_cnt + 1'b1;
  end

  AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && host_we && (host_addr == 4'd2 || host_addr == 4'd3) |=> $stable(ptr)); // R12
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req)); // R6
  AST_DONE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> isr_bit); // R5
  AST_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wait_cnt >= 16'(EXEC_CYCLES - 1)); // R5
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (status == 8'h01 || status == 8'h10 || status == 8'h11 || status == 8'h12)); // R7
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    isr_bit && !done && host_we && host_addr == 4'd8 && host_wdata[0] |=> !isr_bit); // R9
endmodule

bind mbx_vreg_bridge mbx_bridge_chk #(.EXEC_CYCLES(EXEC_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(eng_done), .isr_bit(isr_bit),
  .status(status_q), .ptr(ptr), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .req_valid(req_valid), .req_ready(req_ready), .req(req)
);

// File: tb/sim_mbx_vreg_bridge.sv
module sim_mbx_vreg_bridge;
  localparam int N = 8;
  localparam int DEPTH = 16;
  localparam int NREGS = 16;

  logic clk = 1'b0, rst_n = 1'b0, host_we = 1'b0, host_irq;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  mbx_vreg_bridge #(.MBOX_DEPTH(DEPTH), .EXEC_CYCLES(N), .NREGS(NREGS)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic load(input logic [7:0] t, input logic [7:0] c, input logic [15:0] va, input logic [7:0] v);
    wr(2, 8'h00); wr(3, 8'h80); wr(4, t); wr(5, c);
    wr(2, 8'h04); wr(4, v); wr(6, va[7:0]); wr(7, va[15:8]);
  endtask

  task automatic poll(output int lat);
    logic [7:0] s;
    lat = 0;
    forever begin
      rd(8, s);
      if (s[0] || lat > 400) break;
      @(negedge clk); lat++;
    end
  endtask

  task automatic cmd(input logic [7:0] t, input logic [7:0] c, input logic [15:0] va, input logic [7:0] v,
                     output logic [7:0] st, output logic [7:0] rv, output int lat);
    load(t, c, va, v); wr(0, 8'h01); poll(lat);
    rd(1, st); rd(4, rv); wr(8, 8'h01); wr(1, st);
  endtask

  function automatic logic [7:0] pat(input int b); return 8'(b * 13 + 5); endfunction
  function automatic logic [7:0] vv(input int a);  return 8'(a * 29 + 7); endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] d, st, rv;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    foreach (d[i]) ;
    rd(0, d); check("R1 bell", d, 0);
    rd(1, d); check("R1 status", d, 0);
    rd(2, d); check("R1 ptr lo", d, 0);
    rd(3, d); check("R1 ptr hi", d, 0);
    rd(8, d); check("R1 isr", d, 0);
    rd(9, d); check("R1 isr2", d, 0);
    check("R1 irq", host_irq, 0);
    // R2 pointer bytes
    wr(2, 8'h34); wr(3, 8'h12);
    rd(2, d); check("R2 lo", d, 8'h34);
    rd(3, d); check("R2 hi", d, 8'h12);
    // R3 window: fill all bytes, then sweep every pointer and lane
    for (int j = 0; j < DEPTH / 4; j++) begin
      wr(2, 8'(4 * j)); wr(3, 8'h80);
      for (int k = 0; k < 4; k++) wr(4'(4 + k), pat(4 * j + k));
    end
    for (int i = 0; i < DEPTH; i++) begin
      wr(2, 8'(i));
      for (int k = 0; k < 4; k++) begin
        rd(4'(4 + k), d); check("R3 lane", d, pat((i + k) % DEPTH));
      end
    end
    wr(3, 8'h00); wr(2, 8'h00);
    rd(4, d); check("R3 region0 read", d, 0);
    wr(4, 8'h77); wr(3, 8'h80);
    rd(4, d); check("R3 region0 write ignored", d, pat(0));
    // R4 wrong doorbell value
    load(8'h03, 8'h01, 16'h0000, 8'h99);
    wr(0, 8'h02);
    rd(0, d); check("R4 bad bell idle", d, 0);
    repeat (N + 6) @(negedge clk);
    rd(8, d); check("R4 no completion", d, 0);
    // R6 and R5: write every address, exact latency
    for (int a = 0; a < NREGS; a++) begin
      cmd(8'h03, 8'h01, 16'(a), vv(a), st, rv, lat);
      check("R6 write status", st, 8'h01);
      check("R5 latency ok", lat, N + 2);
    end
    for (int a = 0; a < NREGS; a++) begin
      if (a == 5 || a == 9) continue;
      cmd(8'h02, 8'h01, 16'(a), 8'h00, st, rv, lat);
      check("R6 read value", rv, vv(a));
      check("R6 read status", st, 8'h01);
    end
    rd(1, d); check("R8 cleared by writeback", d, 0);
    rd(8, d); check("R9 cleared", d, 0);
    // R10 16-bit pair freeze
    cmd(8'h02, 8'h01, 16'd4, 8'h00, st, rv, lat);
    cmd(8'h03, 8'h01, 16'd5, 8'hC3, st, rv, lat);
    cmd(8'h02, 8'h01, 16'd5, 8'h00, st, rv, lat); check("R10 frozen hi", rv, vv(5));
    cmd(8'h02, 8'h01, 16'd4, 8'h00, st, rv, lat);
    cmd(8'h02, 8'h01, 16'd5, 8'h00, st, rv, lat); check("R10 relatched hi", rv, 8'hC3);
    // R11 12-bit nibble freeze
    cmd(8'h02, 8'h01, 16'd8, 8'h00, st, rv, lat); check("R11 hi byte", rv, vv(8));
    cmd(8'h03, 8'h01, 16'd9, 8'h5A, st, rv, lat);
    cmd(8'h02, 8'h01, 16'd9, 8'h00, st, rv, lat); check("R11 frozen nib", rv, vv(9));
    cmd(8'h02, 8'h01, 16'd8, 8'h00, st, rv, lat);
    cmd(8'h02, 8'h01, 16'd9, 8'h00, st, rv, lat); check("R11 relatched nib", rv, 8'h5A);
    // R7 packet rejects
    cmd(8'h07, 8'h01, 16'd0, 8'h00, st, rv, lat);
    check("R7 bad type", st, 8'h10); check("R7 bad type latency", lat, N);
    cmd(8'h09, 8'h00, 16'd0, 8'h00, st, rv, lat); check("R7 type before count", st, 8'h10);
    cmd(8'h02, 8'h02, 16'd0, 8'h00, st, rv, lat); check("R7 bad count", st, 8'h11);
    cmd(8'h03, 8'h01, 16'(NREGS), 8'hE1, st, rv, lat);
    check("R7 bad addr", st, 8'h12); check("R7 bad addr latency", lat, N);
    cmd(8'h02, 8'h01, 16'd0, 8'h00, st, rv, lat); check("R7 store untouched", rv, vv(0));
    // R8 status clear only on exact writeback; R9 W1C
    load(8'h03, 8'h01, 16'd2, 8'h42); wr(0, 8'h01); poll(lat);
    wr(1, 8'h00); rd(1, d); check("R8 wrong value kept", d, 8'h01);
    wr(1, 8'h01); rd(1, d); check("R8 exact clears", d, 8'h00);
    check("R9 irq high", host_irq, 1);
    wr(8, 8'hFE); rd(8, d); check("R9 zero bit no effect", d, 8'h01);
    wr(8, 8'h01); rd(8, d); check("R9 w1c", d, 8'h00);
    check("R9 irq low", host_irq, 0);
    // R12 writes ignored while busy; R4 busy readback
    load(8'h03, 8'h01, 16'd3, 8'h66); wr(0, 8'h01);
    rd(0, d); check("R4 busy reads 1", d, 8'h01);
    wr(4, 8'hEE); wr(2, 8'h00); wr(0, 8'h01);
    poll(lat);
    rd(2, d); check("R12 ptr kept", d, 8'h04);
    rd(4, d); check("R12 value kept", d, 8'h66);
    wr(8, 8'h01); wr(1, 8'h01);
    cmd(8'h02, 8'h01, 16'd3, 8'h00, st, rv, lat); check("R12 store value", rv, 8'h66);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule